// File: doc/BRIEF.md
# Activity-Adaptive Scan Shift Pacer

This block paces the serial load of a built-in self-test scan chain. It runs from one fast clock and emits a one-cycle shift enable. That single enable is shared by the random bit source, the scan register and the response analyzer. Each enabled cycle moves one fresh bit from the random source into an N-bit scan register.

The block keeps a live count of the adjacent bit pairs in the chain that hold equal values. A high count means little toggling during the shift, so the block can shift faster without exceeding the power budget. From that count it picks a shift period of 1, 2, 3 or 4 fast-clock cycles. The slowest period is used whenever nothing is yet known about the chain's activity.

A start request launches a scan-in of exactly N shifts. A one-cycle done pulse marks the end of the scan-in, and a cycle counter reports how many fast-clock cycles it used. This makes the saving over a fixed worst-case rate directly measurable.

Top module: `scan_rate_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the chain reads all zeros, the pair count reads N-1, the shift enable, busy and done are 0, and the active period reads 4.
- R2: A start seen while idle begins a scan-in of exactly N shifts. Busy is 1 from the cycle after start until the last shift. Done is 1 for exactly one cycle, the cycle after the last shift, and busy is 0 in that cycle.
- R3: On each shift, the serial input bit enters chain bit 0 and every other bit moves one position toward bit N-1. Without a shift the chain holds its value.
- R4: The pair count always equals the number of indices i in 0..N-2 with chain[i] equal to chain[i+1]. It therefore stays within 0..N-1 and changes only on a shift.
- R5: The period chosen for a count c is 4 when 4c < N, 3 when 4c < 2N, 2 when 4c < 3N, and 1 otherwise.
- R6: In the first scan-in after reset, the first shift uses period 4 whatever the count is.
- R7: Shifts occur on the last cycle of each period. The first period of a scan-in is set from the count at start (subject to R6). Each later period is set from the count right after the previous shift, so a new rate takes effect only at a period boundary.
- R8: The cycle counter clears on an accepted start and adds one for every busy cycle. After done it holds the total number of fast-clock cycles of the scan-in, which equals the sum of its periods, until the next start.
- R9: A start asserted while a scan-in is in progress is ignored. The scan-in still ends after N shifts, with an unchanged cycle total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a scan-in of N shifts |
| rbg_bit | input | 1 | Serial bit from the random source, taken when shift_en is 1 |
| shift_en | output | 1 | Shared shift enable, one fast cycle per shift |
| chain | output | N | Scan register contents, bit 0 is the newest bit |
| nt_count | output | CNT_W | Number of equal adjacent pairs in the chain |
| active_div | output | 3 | Period of the current shift, in fast cycles (1..4) |
| busy | output | 1 | Scan-in in progress |
| done | output | 1 | One-cycle pulse after the last shift |
| cycle_count | output | CYC_W | Fast-clock cycles used by the latest scan-in |

## Verification
The shift enable is decoded from registers. It is therefore valid in the same cycle as the phase that produces it. The bench samples it on the falling edge and, in that same half-cycle, decides which bit the next rising edge will shift in.

The chain, pair count, active period and cycle counter are all updated on the rising edge that performs a shift. The bench compares them on the falling edge one cycle later, against a model that counts pairs afresh from its own copy of the chain. Done and the final cycle total are due one cycle after the last shift. The held total and the return of done to 0 are checked one further cycle on.

// File: rtl/scan_rate_pkg.sv
package scan_rate_pkg;

  typedef logic [2:0] div_t;

  // Period in fast cycles for a given count of equal adjacent pairs,
  // compared in quarters of the chain length without any division.
  function automatic div_t pick_div(input int unsigned cnt, input int unsigned n);
    if (4 * cnt < n)          return 3'd4;
    else if (4 * cnt < 2 * n) return 3'd3;
    else if (4 * cnt < 3 * n) return 3'd2;
    else                      return 3'd1;
  endfunction

endpackage

// File: rtl/nt_monitor.sv
module nt_monitor #(
  parameter int N     = 8,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             in_bit,
  input  logic             head_bit,
  input  logic             tail_eq,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next
);

  logic gain;
  logic loss;

  assign gain = shift_en && (in_bit == head_bit);
  assign loss = shift_en && tail_eq;

  always_comb begin
    case ({gain, loss})
      2'b10:   cnt_next = cnt_q + CNT_W'(1);
      2'b01:   cnt_next = cnt_q - CNT_W'(1);
      default: cnt_next = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= CNT_W'(N - 1);
    else     cnt_q <= cnt_next;
  end

endmodule

// File: rtl/shift_pacer.sv
module shift_pacer
  import scan_rate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic busy,
  input  logic rate_known,
  input  div_t next_div,
  output logic shift_en,
  output div_t div_q
);

  div_t ph_q;

  assign shift_en = busy && (ph_q == div_q - 3'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= '0;
      div_q <= 3'd4;
    end else if (launch) begin
      ph_q  <= '0;
      div_q <= rate_known ? next_div : 3'd4;
    end else if (shift_en) begin
      ph_q  <= '0;
      div_q <= next_div;
    end else if (busy) begin
      ph_q  <= ph_q + 3'd1;
    end
  end

endmodule

// File: rtl/scan_rate_ctrl.sv
module scan_rate_ctrl
  import scan_rate_pkg::*;
#(
  parameter int N     = 8,
  parameter int CNT_W = $clog2(N + 1),
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rbg_bit,
  output logic             shift_en,
  output logic [N-1:0]     chain,
  output logic [CNT_W-1:0] nt_count,
  output logic [2:0]       active_div,
  output logic             busy,
  output logic             done,
  output logic [CYC_W-1:0] cycle_count
);

  localparam int LEFT_W = $clog2(N + 1);

  logic [LEFT_W-1:0] left_q;
  logic              rate_known_q;
  logic              launch;
  logic [CNT_W-1:0]  cnt_next;
  div_t              next_div;

  assign launch   = start && !busy;
  assign next_div = pick_div(int'(cnt_next), N);

  nt_monitor #(.N(N), .CNT_W(CNT_W)) mon_i (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .in_bit   (rbg_bit),
    .head_bit (chain[0]),
    .tail_eq  (chain[N-1] == chain[N-2]),
    .cnt_q    (nt_count),
    .cnt_next (cnt_next)
  );

  shift_pacer pace_i (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .busy       (busy),
    .rate_known (rate_known_q),
    .next_div   (next_div),
    .shift_en   (shift_en),
    .div_q      (active_div)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chain        <= '0;
      left_q       <= '0;
      busy         <= 1'b0;
      done         <= 1'b0;
      rate_known_q <= 1'b0;
      cycle_count  <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy        <= 1'b1;
        left_q      <= LEFT_W'(N);
        cycle_count <= '0;
      end else if (busy) begin
        cycle_count <= cycle_count + CYC_W'(1);
        if (shift_en) begin
          chain        <= {chain[N-2:0], rbg_bit};
          left_q       <= left_q - LEFT_W'(1);
          rate_known_q <= 1'b1;
          if (left_q == LEFT_W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/scan_rate_ctrl_chk.sv
module scan_rate_ctrl_chk #(
  parameter int N     = 8,
  parameter int CNT_W = $clog2(N + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_en,
  input logic             busy,
  input logic             done,
  input logic [N-1:0]     chain,
  input logic [CNT_W-1:0] nt_count,
  input logic [2:0]       active_div,
  input logic             rate_known_q
);

  assert_count_range_R4: assert property (@(posedge clk) disable iff (rst)
    nt_count <= CNT_W'(N - 1));

  assert_count_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(nt_count));

  assert_chain_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(chain));

  assert_shift_in_scan_R2: assert property (@(posedge clk) disable iff (rst)
    shift_en |-> busy);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_div_legal_R5: assert property (@(posedge clk) disable iff (rst)
    (active_div >= 3'd1) && (active_div <= 3'd4));

  assert_first_slow_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !rate_known_q) |-> (active_div == 3'd4));

endmodule

bind scan_rate_ctrl scan_rate_ctrl_chk #(.N(N), .CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .shift_en     (shift_en),
  .busy         (busy),
  .done         (done),
  .chain        (chain),
  .nt_count     (nt_count),
  .active_div   (active_div),
  .rate_known_q (rate_known_q)
);

// File: tb/scan_rate_ctrl_tb_top.sv
`timescale 1ns/1ps
module scan_rate_ctrl_tb_top;

  localparam int N     = 8;
  localparam int CNT_W = $clog2(N + 1);
  localparam int CYC_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             rbg_bit = 1'b0;
  logic             shift_en;
  logic [N-1:0]     chain;
  logic [CNT_W-1:0] nt_count;
  logic [2:0]       active_div;
  logic             busy;
  logic             done;
  logic [CYC_W-1:0] cycle_count;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] model = '0;
  bit known = 0;

  always #2.5 clk = ~clk;

  scan_rate_ctrl #(.N(N), .CNT_W(CNT_W), .CYC_W(CYC_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .rbg_bit(rbg_bit),
    .shift_en(shift_en), .chain(chain), .nt_count(nt_count),
    .active_div(active_div), .busy(busy), .done(done),
    .cycle_count(cycle_count)
  );

  function automatic int pairs(input logic [N-1:0] v);
    int p = 0;
    for (int i = 0; i < N - 1; i++) if (v[i] == v[i+1]) p++;
    return p;
  endfunction

  function automatic int exp_div(input int c);
    if (4 * c < N)          return 4;
    else if (4 * c < 2 * N) return 3;
    else if (4 * c < 3 * N) return 2;
    return 1;
  endfunction

  function automatic logic gen_bit(input int mode, input int k);
    case (mode)
      1:       return 1'b0;
      2:       return k[0];
      3:       return 1'b1;
      5:       return k[1];
      default: return 1'($urandom_range(0, 1));
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_idle_reset();
    check("R1 chain", int'(chain), 0);
    check("R1 count", int'(nt_count), N - 1);
    check("R1 shift_en", int'(shift_en), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 period", int'(active_div), 4);
  endtask

  // Runs one scan-in; mode 4 is random bits with a stray start mid-scan (R9).
  task automatic run_scan(input int mode);
    int gap = 0;
    int shifts = 0;
    int total = 0;
    int expd;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    expd = known ? exp_div(pairs(model)) : 4;
    check(known ? "R7 first period" : "R6 first period", int'(active_div), expd);
    check("R2 busy", int'(busy), 1);
    while (shifts < N) begin
      gap++;
      total++;
      rbg_bit = gen_bit(mode, shifts);
      start = (mode == 4 && shifts == 3) ? 1'b1 : 1'b0;
      if (shift_en) begin
        check(known ? "R7 shift gap" : "R6 shift gap", gap, expd);
        model = {model[N-2:0], rbg_bit};
        known = 1;
        expd = exp_div(pairs(model));
        shifts++;
        gap = 0;
      end else if (gap > 6) begin
        check("R7 shift timeout", gap, expd);
        shifts = N;
      end
      @(negedge clk);
      start = 1'b0;
      if (shifts > 0 && shifts < N) begin
        check("R4 count", int'(nt_count), pairs(model));
        check("R5 period", int'(active_div), expd);
      end
    end
    check("R2 done", int'(done), 1);
    check("R2 busy end", int'(busy), 0);
    check("R3 chain", int'(chain), int'(model));
    check("R4 count end", int'(nt_count), pairs(model));
    check(mode == 4 ? "R9 total" : "R8 total", int'(cycle_count), total);
    @(negedge clk);
    check("R2 done falls", int'(done), 0);
    check("R8 total held", int'(cycle_count), total);
    check("R3 chain held", int'(chain), int'(model));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_idle_reset();
    rst = 1'b0;
    @(negedge clk);
    check_idle_reset();
    run_scan(1);               // R6: count N-1 but first shift stays slow
    run_scan(1);               // all-equal chain, fastest rate
    run_scan(2);               // alternating, slowest rate
    run_scan(3);
    run_scan(5);
    run_scan(4);               // R9 stray start
    for (int t = 0; t < 20; t++) run_scan(0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    model = '0; known = 0;
    check_idle_reset();
    rst = 1'b0;
    @(negedge clk);
    run_scan(1);
    run_scan(0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule